// File: doc/BRIEF.md
# Interrupt In-Service Gate

This block decides whether a simple processor core should take an interrupt. It keeps a small 8-bit control register with two live bits: a global enable and an in-service flag. Each interrupt source has a pending line and a local enable. The block combines these into one request and gates that request with the two register bits. The result is a single registered take-interrupt signal for the core.

When the core acknowledges an interrupt, hardware sets the in-service flag. This blocks any further interrupt until the flag is cleared. A handler may clear the flag itself to allow nested interrupts. A return-from-interrupt or pop-state strobe also clears it.

At acknowledge time a fixed-priority encoder captures the index of the winning source, so the core can dispatch. Among several enabled sources, the lowest-numbered one wins.

Top module: `irq_gate`

## Requirements
- R1: After reset, `ctl_rd` is 8'h00, `take_o` is 0 and `src_idx_o` is 0.
- R2: Bits 7:2 of `ctl_rd` always read 0, even after a write of all ones. Bit 0 is the global enable and bit 1 is the in-service flag.
- R3: While the global enable (bit 0) is 0, `take_o` never asserts, whatever the request and local enable lines do.
- R4: A source counts only if both its request bit and its local enable bit are 1. `take_o` is 1 in the cycle after a cycle in which some source counts and the register state after that cycle's edge has global enable 1 and in-service 0; otherwise `take_o` is 0.
- R5: An acknowledge sets the in-service bit, seen on `ctl_rd[1]` the next cycle. `take_o` is 0 in the cycle after an acknowledge.
- R6: While the in-service bit is 1, `take_o` stays 0.
- R7: A software write with bit 1 = 0 clears the in-service bit, and a still-pending enabled source is taken again the next cycle (nesting).
- R8: A return strobe (`reti_i`) clears the in-service bit.
- R9: When an acknowledge comes in the same cycle as a software clear or a return strobe, the hardware set wins and in-service ends up 1.
- R10: When a return strobe and a register write come in the same cycle without an acknowledge, in-service is cleared regardless of the written bit 1. The global enable still takes the written bit 0.
- R11: On acknowledge, `src_idx_o` loads the binary index of the lowest-numbered counting source, or 0 if none counts. It holds that value until the next acknowledge.
- R12: The global enable changes only on a register write. Acknowledge and return strobes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NSRC | Pending request per source |
| irq_en | input | NSRC | Local enable per source |
| ack_i | input | 1 | Interrupt acknowledge strobe from the core |
| reti_i | input | 1 | Return-from-interrupt / pop-state strobe |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| ctl_rd | output | 8 | Control register read value |
| take_o | output | 1 | Registered take-interrupt request |
| src_idx_o | output | SRC_W | Source index captured at acknowledge |

## Verification
The assertions assume the core acknowledges only in response to the protocol. They hold whatever the strobes do, since an acknowledge without a pending take only sets in-service. The assertions also assume every input is stable around the rising edge. The stimulus changes inputs only on the falling edge. It deliberately drives acknowledge together with a return strobe or a software clear, so the precedence rules are exercised rather than avoided.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int CTL_W       = 8;
  localparam int CTL_IGE_BIT = 0;
  localparam int CTL_INS_BIT = 1;

  typedef struct packed {
    logic ins;
    logic ige;
  } ctl_bits_t;

  function automatic logic [CTL_W-1:0] pack_ctl(ctl_bits_t c);
    logic [CTL_W-1:0] v;
    v = '0;
    v[CTL_IGE_BIT] = c.ige;
    v[CTL_INS_BIT] = c.ins;
    return v;
  endfunction
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NSRC  = 8,
  parameter int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]  req,
  input  logic [NSRC-1:0]  en,
  output logic             any_o,
  output logic [SRC_W-1:0] idx_o
);
  logic [NSRC-1:0] live;

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_mask
      assign live[g] = req[g] & en[g];
    end
  endgenerate

  // Lowest index wins: scan from the top down, last hit overrides.
  always_comb begin
    idx_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (live[i]) idx_o = SRC_W'(i);
    end
  end

  assign any_o = |live;
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import irq_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             ack,
  input  logic             reti,
  output ctl_bits_t        ctl_d,
  output ctl_bits_t        ctl_q
);
  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) begin
      ctl_d.ige = wr_data[CTL_IGE_BIT];
      ctl_d.ins = wr_data[CTL_INS_BIT];
    end
    if (reti) ctl_d.ins = 1'b0;
    if (ack)  ctl_d.ins = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      ctl_q <= ctl_d;
    end
  end

  AST_ACK_SETS_INS: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> ctl_q.ins);  // R5
  AST_ACK_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && (reti || (wr_en && !wr_data[CTL_INS_BIT]))) |=> ctl_q.ins);  // R9
  AST_RETI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ack) |=> !ctl_q.ins);  // R8
  AST_IGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctl_q.ige));  // R12
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_gate_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  irq_req,
  input  logic [NSRC-1:0]  irq_en,
  input  logic             ack_i,
  input  logic             reti_i,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       ctl_rd,
  output logic             take_o,
  output logic [SRC_W-1:0] src_idx_o
);
  logic             any_live;
  logic [SRC_W-1:0] win_idx;
  ctl_bits_t        ctl_d, ctl_q;
  logic             take_d, take_q;
  logic [SRC_W-1:0] idx_d, idx_q;

  irq_prio_enc #(.NSRC(NSRC), .SRC_W(SRC_W)) u_enc (
    .req   (irq_req),
    .en    (irq_en),
    .any_o (any_live),
    .idx_o (win_idx)
  );

  irq_ctl_reg u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ack     (ack_i),
    .reti    (reti_i),
    .ctl_d   (ctl_d),
    .ctl_q   (ctl_q)
  );

  // Gate against the register state that will hold after this edge.
  always_comb begin
    take_d = any_live & ctl_d.ige & ~ctl_d.ins;
    idx_d  = idx_q;
    if (ack_i) idx_d = win_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      take_q <= take_d;
      idx_q  <= idx_d;
    end
  end

  assign ctl_rd    = pack_ctl(ctl_q);
  assign take_o    = take_q;
  assign src_idx_o = idx_q;

  AST_TAKE_NEEDS_IGE: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ctl_rd[CTL_IGE_BIT]);  // R3
  AST_TAKE_BLOCKED_INS: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !ctl_rd[CTL_INS_BIT]);  // R6
  AST_TAKE_DROPS_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> !take_o);  // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd[7:2] == '0);  // R2
  AST_PRIO_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    any_live |-> (irq_req[win_idx] && irq_en[win_idx]
                  && ((irq_req & irq_en & ((NSRC'(1) << win_idx) - NSRC'(1))) == '0)));  // R11
endmodule

// File: tb/tb_irq_gate.sv
`timescale 1ns/1ps
module tb_irq_gate;
  localparam int NSRC  = 8;
  localparam int SRC_W = 3;
  localparam int NVEC  = 14;

  logic             clk;
  logic             rst_n;
  logic [NSRC-1:0]  irq_req, irq_en;
  logic             ack_i, reti_i, wr_en;
  logic [7:0]       wr_data;
  logic [7:0]       ctl_rd;
  logic             take_o;
  logic [SRC_W-1:0] src_idx_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  irq_gate #(.NSRC(NSRC), .SRC_W(SRC_W)) dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
    .ack_i(ack_i), .reti_i(reti_i), .wr_en(wr_en), .wr_data(wr_data),
    .ctl_rd(ctl_rd), .take_o(take_o), .src_idx_o(src_idx_o)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // {wr, wdata[8], req[8], en[8], ack, reti, exp_ctl[8], exp_take, exp_idx[3]}
  localparam logic [38:0] VEC [NVEC] = '{
    {1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0}, // 0  R1 idle
    {1'b1, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, 8'h03, 1'b0, 3'd0}, // 1  R2 write ones
    {1'b0, 8'h00, 8'h10, 8'hFF, 1'b0, 1'b0, 8'h03, 1'b0, 3'd0}, // 2  R6 blocked
    {1'b1, 8'h01, 8'h10, 8'hFF, 1'b0, 1'b0, 8'h01, 1'b1, 3'd0}, // 3  R7 sw clear
    {1'b0, 8'h00, 8'h10, 8'h0F, 1'b0, 1'b0, 8'h01, 1'b0, 3'd0}, // 4  R4 not local
    {1'b0, 8'h00, 8'h14, 8'hFF, 1'b1, 1'b0, 8'h03, 1'b0, 3'd2}, // 5  R5 R11 ack
    {1'b0, 8'h00, 8'h14, 8'hFF, 1'b0, 1'b1, 8'h01, 1'b1, 3'd2}, // 6  R8 reti
    {1'b1, 8'h01, 8'h80, 8'hFF, 1'b1, 1'b0, 8'h03, 1'b0, 3'd7}, // 7  R9 ack vs clear
    {1'b0, 8'h00, 8'h00, 8'hFF, 1'b1, 1'b1, 8'h03, 1'b0, 3'd0}, // 8  R9 R12 ack vs reti
    {1'b1, 8'h03, 8'h00, 8'h00, 1'b0, 1'b1, 8'h01, 1'b0, 3'd0}, // 9  R10 reti vs write
    {1'b1, 8'h00, 8'hFF, 8'hFF, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0}, // 10 R3 disable
    {1'b0, 8'h00, 8'hFF, 8'hFF, 1'b0, 1'b1, 8'h00, 1'b0, 3'd0}, // 11 R3 R12 still off
    {1'b1, 8'h01, 8'h60, 8'h40, 1'b0, 1'b0, 8'h01, 1'b1, 3'd0}, // 12 R4 local enable
    {1'b0, 8'h00, 8'h60, 8'h40, 1'b1, 1'b0, 8'h03, 1'b0, 3'd6}  // 13 R11 masked prio
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R1";   1: return "R2";   2: return "R6";   3: return "R7";
      4: return "R4";   5: return "R5/R11"; 6: return "R8"; 7: return "R9";
      8: return "R9/R12"; 9: return "R10"; 10: return "R3"; 11: return "R3/R12";
      12: return "R4";  default: return "R11";
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    irq_req = '0; irq_en = '0; ack_i = 0; reti_i = 0; wr_en = 0; wr_data = '0;
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    #1;
    check("R1", "ctl in reset", int'(ctl_rd), 0);
    check("R1", "take in reset", int'(take_o), 0);
    check("R1", "idx in reset", int'(src_idx_o), 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [38:0] v;
      v = VEC[i];
      wr_en   = v[38];
      wr_data = v[37:30];
      irq_req = v[29:22];
      irq_en  = v[21:14];
      ack_i   = v[13];
      reti_i  = v[12];
      @(negedge clk);
      check(vtag(i), $sformatf("vec %0d ctl", i), int'(ctl_rd), int'(v[11:4]));
      check(vtag(i), $sformatf("vec %0d take", i), int'(take_o), int'(v[3]));
      check(vtag(i), $sformatf("vec %0d idx", i), int'(src_idx_o), int'(v[2:0]));
    end

    // R11: index holds across non-acknowledge cycles with other requests
    idle_inputs();
    irq_req = 8'h01; irq_en = 8'hFF;
    @(negedge clk);
    check("R11", "idx hold", int'(src_idx_o), 6);

    // R1: asynchronous reset in the middle of activity
    wr_en = 1; wr_data = 8'h01; irq_req = 8'h08; irq_en = 8'hFF;
    @(negedge clk);
    wr_en = 0;
    check("R4", "take before reset", int'(take_o), 1);
    #1 rst_n = 0;
    #1;
    check("R1", "ctl after mid reset", int'(ctl_rd), 0);
    check("R1", "take after mid reset", int'(take_o), 0);
    idle_inputs();
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "ctl after release", int'(ctl_rd), 0);
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (2000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule